// File: doc/BRIEF.md
# Lane-Partitioned Packed ALU with Saturation

This unit runs one operation on a 64-bit word that it treats as a set of independent lanes: eight bytes, four halfwords, two words, or one doubleword, picked per operation by a lane-size code. A single byte-segmented adder serves every lane size. At each byte boundary, a gate either passes the carry from the byte below or replaces it with a fresh lane carry-in. Wrapping and clamping arithmetic, equality and greater-than masks, lane-confined logical shifts, unsigned absolute difference, and lane-wise maximum and minimum all reuse the same adder flags.

The operands, an opcode, the lane size and a signedness flag enter together under an input valid. One clock later the result leaves a register with a matching valid. When no valid input arrives, the register keeps its last value.

Top module: `simd_alu`

## Requirements
- R1: The lane-size code selects 8-bit (0), 16-bit (1), 32-bit (2) or 64-bit (3) lanes. Opcode 0 (wrapping add) and opcode 1 (wrapping subtract) compute each lane modulo its width, and no carry or borrow crosses into the next lane.
- R2: Opcode 4 (AND), opcode 5 (OR) and opcode 6 (XOR) give the same 64-bit result for every lane size and for either value of the signedness flag.
- R3: Opcode 2 (clamping add) with the signedness flag at 0 returns an all-ones lane when the unsigned sum overflows. With the flag at 1, a signed overflow yields the most positive lane value if operand A's lane is non-negative and the most negative lane value otherwise.
- R4: Opcode 3 (clamping subtract) with the signedness flag at 0 returns a zero lane when B exceeds A. With the flag at 1, a signed overflow clamps toward the sign of operand A's lane, as in R3.
- R5: Opcode 7 (equal) and opcode 8 (greater-than, signed when the signedness flag is 1) set a lane to all ones when the condition is true and to all zeros when it is false.
- R6: Opcode 9 (shift left) and opcode 10 (shift right) are logical shifts of each lane of A by the count in B[7:0]. Bits never move between lanes, and a count equal to or above the lane width gives zero.
- R7: Opcode 11 returns the unsigned absolute difference of each lane, whatever the signedness flag says.
- R8: Opcode 12 returns the lane-wise maximum and opcode 13 the lane-wise minimum, compared signed when the signedness flag is 1 and unsigned otherwise.
- R9: The output valid is high exactly one cycle after a cycle with the input valid high, and the result of that input is presented in the same cycle.
- R10: A cycle with the input valid low leaves the result unchanged and drops the output valid in the following cycle.
- R11: While the active-low reset is low, the output valid and the result are cleared to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand; B[7:0] is the shift count |
| opcode | input | 4 | Operation select, codes per R1 to R8 |
| lane_sz | input | 2 | Lane width code per R1 |
| is_signed | input | 1 | Signed interpretation for clamping, compares, max and min |
| out_vld | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered packed result |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. These are the one-cycle valid pairing, result retention in idle cycles, the clear under reset, and the lane-size independence of AND and XOR. They also check that every compare lane comes out fully set or fully clear, and that a 64-bit unsigned clamping add never drops below its operands and a clamping subtract never rises above operand A. Other behaviour depends on exact lane values: gating carries at 16- and 32-bit boundaries, the clamp direction under signed overflow, shift counts at and beyond the lane width, and the choice of signedness for maximum and minimum. Only the bench's computed vectors can show these.

// File: rtl/simd_alu_pkg.sv
// Shared definitions for the lane-partitioned packed ALU.
// Assumes an 8-bit byte as the partition grain and at most a 64-bit lane.
package simd_alu_pkg;

    localparam int BYTE_W = 8;

    // Operation codes; the numeric values are part of the block's interface.
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDS  = 4'd2,
        OP_SUBS  = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_CMPEQ = 4'd7,
        OP_CMPGT = 4'd8,
        OP_SHL   = 4'd9,
        OP_SHR   = 4'd10,
        OP_ABSD  = 4'd11,
        OP_MAX   = 4'd12,
        OP_MIN   = 4'd13
    } simd_op_e;

    // Lane width codes: lane bytes = 1 << code.
    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_sz_e;

endpackage

// File: rtl/simd_seg_adder.sv
// Byte-segmented adder/subtractor.
// Each byte takes its carry from the byte below, unless it opens a lane,
// in which case it takes the lane carry-in (1 for subtract, 0 for add).
// Reports the carry out of and the signed overflow of every byte; the
// flags of a lane's top byte describe the whole lane.
// Assumes DATA_W = 8 * 2^k bytes and a lane code no larger than log2(bytes).
module simd_seg_adder
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic                     sub,
    input  logic [1:0]               lane_sz,
    output logic [DATA_W-1:0]        sum,
    output logic [DATA_W/BYTE_W-1:0] byte_cout,
    output logic [DATA_W/BYTE_W-1:0] byte_sovf
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int IDXW   = $clog2(NBYTES);

    logic [DATA_W-1:0] b_eff;
    logic [IDXW-1:0]   lmask;

    // Invert B for subtract and derive the in-lane byte index mask.
    always_comb begin
        b_eff = sub ? ~b : b;
        lmask = IDXW'((32'd1 << lane_sz) - 32'd1);
    end

    // Ripple through the bytes, restarting the carry at every lane start.
    always_comb begin
        logic       c;
        logic [7:0] lo;
        logic [1:0] hi;
        c = 1'b0;
        sum = '0;
        byte_cout = '0;
        byte_sovf = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if ((IDXW'(i) & lmask) == '0) begin
                c = sub;
            end
            lo = {1'b0, a[BYTE_W*i +: BYTE_W-1]} + {1'b0, b_eff[BYTE_W*i +: BYTE_W-1]} + {7'd0, c};
            hi = {1'b0, a[BYTE_W*i+BYTE_W-1]} + {1'b0, b_eff[BYTE_W*i+BYTE_W-1]} + {1'b0, lo[7]};
            sum[BYTE_W*i +: BYTE_W] = {hi[0], lo[6:0]};
            byte_cout[i] = hi[1];
            byte_sovf[i] = hi[1] ^ lo[7];
            c = hi[1];
        end
    end

endmodule

// File: rtl/simd_seg_shifter.sv
// Lane-confined logical shifter.
// Shifts the whole word by the count, then clears every bit whose source
// lay outside its own lane, so nothing crosses a lane boundary and a count
// at or beyond the lane width leaves the lane at zero.
// Assumes an 8-bit count and lane widths of 8 << lane_sz bits.
module simd_seg_shifter
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [7:0]        cnt,
    input  logic              dir_right,
    input  logic [1:0]        lane_sz,
    output logic [DATA_W-1:0] y
);

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] keep;
    int                lane_w;

    // Whole-word shift and the current lane width in bits.
    always_comb begin
        raw    = dir_right ? (a >> cnt) : (a << cnt);
        lane_w = BYTE_W << lane_sz;
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        // Keep bit k only if its source bit sits in the same lane.
        always_comb begin
            int pos;
            pos = k & (lane_w - 1);
            if (dir_right) begin
                keep[k] = (pos + int'(cnt)) < lane_w;
            end else begin
                keep[k] = pos >= int'(cnt);
            end
        end
    end

    // Apply the lane mask.
    always_comb begin
        y = raw & keep;
    end

endmodule

// File: rtl/simd_alu.sv
// Lane-partitioned packed ALU with wrapping and clamping arithmetic.
// Two segmented adders run in parallel: A op B (add or subtract) and B - A.
// The first gives sums, differences and clamp flags; the second gives the
// greater-than decision (signed or unsigned) and the reversed difference
// for absolute difference. Per-byte selection then builds the result,
// which is registered together with a valid bit.
// Assumes a 64-bit word; unused opcodes 14 and 15 produce zero.
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        opcode,
    input  logic [1:0]        lane_sz,
    input  logic              is_signed,
    output logic              out_vld,
    output logic [DATA_W-1:0] result
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int IDXW   = $clog2(NBYTES);

    simd_op_e          op;
    logic              sub_ab;
    logic [IDXW-1:0]   lmask;
    logic [DATA_W-1:0] s_ab, s_ba, sh_y, nxt;
    logic [NBYTES-1:0] co_ab, ov_ab, co_ba, ov_ba;

    // Decode the opcode and pick the first adder's direction.
    always_comb begin
        op     = simd_op_e'(opcode);
        sub_ab = (op == OP_SUB) || (op == OP_SUBS) || (op == OP_ABSD);
        lmask  = IDXW'((32'd1 << lane_sz) - 32'd1);
    end

    simd_seg_adder #(.DATA_W(DATA_W)) i_add_ab (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (sub_ab),
        .lane_sz   (lane_sz),
        .sum       (s_ab),
        .byte_cout (co_ab),
        .byte_sovf (ov_ab)
    );

    simd_seg_adder #(.DATA_W(DATA_W)) i_sub_ba (
        .a         (opnd_b),
        .b         (opnd_a),
        .sub       (1'b1),
        .lane_sz   (lane_sz),
        .sum       (s_ba),
        .byte_cout (co_ba),
        .byte_sovf (ov_ba)
    );

    simd_seg_shifter #(.DATA_W(DATA_W)) i_shift (
        .a         (opnd_a),
        .cnt       (opnd_b[7:0]),
        .dir_right (op == OP_SHR),
        .lane_sz   (lane_sz),
        .y         (sh_y)
    );

    // Build each result byte from its lane's flags.
    always_comb begin
        logic [IDXW-1:0] top;
        logic            gt_u, gt_s, gt, eq, neg;
        logic [7:0]      clamp, ab, bb, sab, sba;
        nxt = '0;
        for (int i = 0; i < NBYTES; i++) begin
            top  = IDXW'(i) | lmask;
            gt_u = !co_ba[top];
            gt_s = s_ba[BYTE_W*top + BYTE_W-1] ^ ov_ba[top];
            gt   = is_signed ? gt_s : gt_u;
            eq   = 1'b1;
            for (int j = 0; j < NBYTES; j++) begin
                if (((IDXW'(j) | lmask) == top) &&
                    (opnd_a[BYTE_W*j +: BYTE_W] != opnd_b[BYTE_W*j +: BYTE_W])) begin
                    eq = 1'b0;
                end
            end
            neg   = opnd_a[BYTE_W*top + BYTE_W-1];
            if (IDXW'(i) == top) begin
                clamp = neg ? 8'h80 : 8'h7F;
            end else begin
                clamp = neg ? 8'h00 : 8'hFF;
            end
            ab  = opnd_a[BYTE_W*i +: BYTE_W];
            bb  = opnd_b[BYTE_W*i +: BYTE_W];
            sab = s_ab[BYTE_W*i +: BYTE_W];
            sba = s_ba[BYTE_W*i +: BYTE_W];
            case (op)
                OP_ADD, OP_SUB: nxt[BYTE_W*i +: BYTE_W] = sab;
                OP_ADDS: begin
                    if (is_signed) begin
                        nxt[BYTE_W*i +: BYTE_W] = ov_ab[top] ? clamp : sab;
                    end else begin
                        nxt[BYTE_W*i +: BYTE_W] = co_ab[top] ? 8'hFF : sab;
                    end
                end
                OP_SUBS: begin
                    if (is_signed) begin
                        nxt[BYTE_W*i +: BYTE_W] = ov_ab[top] ? clamp : sab;
                    end else begin
                        nxt[BYTE_W*i +: BYTE_W] = co_ab[top] ? sab : 8'h00;
                    end
                end
                OP_AND:   nxt[BYTE_W*i +: BYTE_W] = ab & bb;
                OP_OR:    nxt[BYTE_W*i +: BYTE_W] = ab | bb;
                OP_XOR:   nxt[BYTE_W*i +: BYTE_W] = ab ^ bb;
                OP_CMPEQ: nxt[BYTE_W*i +: BYTE_W] = eq ? 8'hFF : 8'h00;
                OP_CMPGT: nxt[BYTE_W*i +: BYTE_W] = gt ? 8'hFF : 8'h00;
                OP_SHL, OP_SHR: nxt[BYTE_W*i +: BYTE_W] = sh_y[BYTE_W*i +: BYTE_W];
                OP_ABSD:  nxt[BYTE_W*i +: BYTE_W] = gt_u ? sab : sba;
                OP_MAX:   nxt[BYTE_W*i +: BYTE_W] = gt ? ab : bb;
                OP_MIN:   nxt[BYTE_W*i +: BYTE_W] = gt ? bb : ab;
                default:  nxt[BYTE_W*i +: BYTE_W] = 8'h00;
            endcase
        end
    end

    // Output register: capture on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            result  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                result <= nxt;
            end
        end
    end

endmodule

// File: rtl/simd_alu_chk.sv
// Property checker for the packed ALU, bound to every simd_alu instance.
// Observes only the top-level ports.
module simd_alu_chk
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [3:0]        opcode,
    input logic [1:0]        lane_sz,
    input logic              is_signed,
    input logic              out_vld,
    input logic [DATA_W-1:0] result
);

    // True when every byte of w is either all ones or all zeros.
    function automatic logic bytes_filled(input logic [DATA_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W / BYTE_W; i++) begin
            if ((w[BYTE_W*i +: BYTE_W] != 8'h00) && (w[BYTE_W*i +: BYTE_W] != 8'hFF)) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R9
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld); // R10
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> $stable(result)); // R10
    AST_AND_LANE_FREE: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && opcode == OP_AND) |=> result == ($past(opnd_a) & $past(opnd_b))); // R2
    AST_XOR_LANE_FREE: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && opcode == OP_XOR) |=> result == ($past(opnd_a) ^ $past(opnd_b))); // R2
    AST_CMP_FILLED: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && (opcode == OP_CMPEQ || opcode == OP_CMPGT)) |=> bytes_filled(result)); // R5
    AST_UADDS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && opcode == OP_ADDS && !is_signed && lane_sz == LANE_B64) |=> (result >= $past(opnd_a) && result >= $past(opnd_b))); // R3
    AST_USUBS_CEIL: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && opcode == OP_SUBS && !is_signed && lane_sz == LANE_B64) |=> result <= $past(opnd_a)); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_vld && result == '0)); // R11

endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) i_simd_alu_chk (.*);

// File: tb/test_simd_alu.sv
// Self-checking bench: a vector table walked by one loop, then directed
// checks of reset, idle hold and latency.
module test_simd_alu;

    localparam int NV = 33;
    localparam int VW = 4 + 2 + 1 + 64 * 3;

    // {opcode, lane_sz, signed, A, B, expected}
    localparam logic [VW-1:0] TBL [NV] = '{
        {4'd0, 2'd0, 1'b0, 64'h00FF7F800102FFFF, 64'h0001018001020001, 64'h000080000204FF00}, // R1 bytes
        {4'd0, 2'd1, 1'b0, 64'h00FF7F800102FFFF, 64'h0001018001020001, 64'h0100810002040000}, // R1 halfwords
        {4'd0, 2'd3, 1'b0, 64'h00FF7F800102FFFF, 64'h0001018001020001, 64'h0100810002050000}, // R1 doubleword
        {4'd0, 2'd2, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'hFFFFFFFF00000000}, // R1 words
        {4'd1, 2'd0, 1'b0, 64'h0010000000000005, 64'h0001000100000006, 64'h000F00FF000000FF}, // R1 sub bytes
        {4'd1, 2'd1, 1'b0, 64'h0010000000000005, 64'h0001000100000006, 64'h000FFFFF0000FFFF}, // R1 sub halfwords
        {4'd4, 2'd0, 1'b0, 64'hF0F0AAAA12345678, 64'hFF000F0FFFFF0000, 64'hF0000A0A12340000}, // R2 and
        {4'd5, 2'd3, 1'b0, 64'hF0F0AAAA12345678, 64'hFF000F0FFFFF0000, 64'hFFF0AFAFFFFF5678}, // R2 or
        {4'd6, 2'd1, 1'b1, 64'hF0F0AAAA12345678, 64'hFF000F0FFFFF0000, 64'h0FF0A5A5EDCB5678}, // R2 xor
        {4'd2, 2'd0, 1'b0, 64'hF00180FF007F10FE, 64'h2001800100011001, 64'hFF02FFFF008020FF}, // R3 unsigned
        {4'd2, 2'd0, 1'b1, 64'hF00180FF007F10FE, 64'h2001800100011001, 64'h10028000007F20FF}, // R3 signed
        {4'd2, 2'd2, 1'b1, 64'h7FFFFFF080000000, 64'h00000020FFFFFFFF, 64'h7FFFFFFF80000000}, // R3 signed words
        {4'd2, 2'd3, 1'b0, 64'hFFFFFFFFFFFFFFF0, 64'h0000000000000020, 64'hFFFFFFFFFFFFFFFF}, // R3 unsigned 64
        {4'd3, 2'd1, 1'b0, 64'h0005FFFF80000100, 64'h0006000100010100, 64'h0000FFFE7FFF0000}, // R4 unsigned
        {4'd3, 2'd1, 1'b1, 64'h0005FFFF80000100, 64'h0006000100010100, 64'hFFFFFFFE80000000}, // R4 signed
        {4'd3, 2'd1, 1'b1, 64'h7FFF000080000010, 64'hFFFF80007FFF0020, 64'h7FFF7FFF8000FFF0}, // R4 signed both ends
        {4'd7, 2'd0, 1'b0, 64'h1122334455667788, 64'h1100334400667700, 64'hFF00FFFF00FFFF00}, // R5 eq bytes
        {4'd7, 2'd1, 1'b0, 64'h1122334455667788, 64'h1100334400667700, 64'h0000FFFF00000000}, // R5 eq halfwords
        {4'd8, 2'd0, 1'b0, 64'h800105FF007F1010, 64'h7F02050001800F11, 64'hFF0000FF0000FF00}, // R5 gt unsigned
        {4'd8, 2'd0, 1'b1, 64'h800105FF007F1010, 64'h7F02050001800F11, 64'h0000000000FFFF00}, // R5 gt signed
        {4'd8, 2'd3, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF}, // R5 gt unsigned 64
        {4'd8, 2'd3, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'h0000000000000000}, // R5 gt signed 64
        {4'd9, 2'd0, 1'b0, 64'hFF01804020100807, 64'h0000000000000003, 64'hF808000000804038}, // R6 shl bytes
        {4'd10, 2'd1, 1'b0, 64'hFF01804020100807, 64'h0000000000000004, 64'h0FF0080402010080}, // R6 shr halfwords
        {4'd9, 2'd0, 1'b0, 64'hFF01804020100807, 64'h0000000000000008, 64'h0000000000000000}, // R6 count = width
        {4'd10, 2'd2, 1'b0, 64'h800000007FFFFFFF, 64'h000000000000001F, 64'h0000000100000000}, // R6 shr words
        {4'd9, 2'd3, 1'b0, 64'h0000000000000001, 64'h000000000000003F, 64'h8000000000000000}, // R6 shl 63
        {4'd9, 2'd3, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000040, 64'h0000000000000000}, // R6 count 64
        {4'd11, 2'd0, 1'b1, 64'h10F0008005FF007F, 64'h2010FF7F05000180, 64'h10E0FF0100FF0101}, // R7 absdiff
        {4'd12, 2'd0, 1'b0, 64'h80017F0012345678, 64'h7F02807F34127856, 64'h8002807F34347878}, // R8 max unsigned
        {4'd12, 2'd0, 1'b1, 64'h80017F0012345678, 64'h7F02807F34127856, 64'h7F027F7F34347878}, // R8 max signed
        {4'd13, 2'd1, 1'b1, 64'h80017F0012345678, 64'h7F02807F34127856, 64'h8001807F12345678}, // R8 min signed
        {4'd13, 2'd1, 1'b0, 64'h80017F0012345678, 64'h7F02807F34127856, 64'h7F027F0012345678}  // R8 min unsigned
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [3:0]  opcode = '0;
    logic [1:0]  lane_sz = '0;
    logic        is_signed = 1'b0;
    logic        out_vld;
    logic [63:0] result;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_alu i_simd_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .opcode    (opcode),
        .lane_sz   (lane_sz),
        .is_signed (is_signed),
        .out_vld   (out_vld),
        .result    (result)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:        return "R1";
            4'd4, 4'd5, 4'd6:  return "R2";
            4'd2:              return "R3";
            4'd3:              return "R4";
            4'd7, 4'd8:        return "R5";
            4'd9, 4'd10:       return "R6";
            4'd11:             return "R7";
            default:           return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%016h expected=%016h", req, what, act, exp);
        end
    endtask

    initial begin
        logic [63:0] last_exp;
        last_exp = '0;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "out_vld in reset", {63'd0, out_vld}, 64'd0);
        check("R11", "result in reset", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "out_vld idle after reset", {63'd0, out_vld}, 64'd0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] row;
            row       = TBL[v];
            opcode    = row[198:195];
            lane_sz   = row[194:193];
            is_signed = row[192];
            opnd_a    = row[191:128];
            opnd_b    = row[127:64];
            in_vld    = 1'b1;
            @(negedge clk);
            check("R9", "out_vld after valid", {63'd0, out_vld}, 64'd1);
            check(req_of(row[198:195]), $sformatf("vector %0d", v), result, row[63:0]);
            last_exp = row[63:0];
        end

        // R10: idle cycles keep the result and drop the valid
        in_vld = 1'b0;
        opcode = 4'd5;
        opnd_a = 64'hFFFFFFFFFFFFFFFF;
        opnd_b = 64'h1234123412341234;
        @(negedge clk);
        check("R10", "out_vld idle", {63'd0, out_vld}, 64'd0);
        @(negedge clk);
        check("R10", "result held", result, last_exp);

        // R9: a single valid pulse gives a single output valid
        opcode = 4'd6; lane_sz = 2'd0; is_signed = 1'b0;
        opnd_a = 64'h00000000000000F0; opnd_b = 64'h000000000000000F;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check("R9", "pulse result", result, 64'h00000000000000FF);
        check("R9", "pulse valid", {63'd0, out_vld}, 64'd1);
        @(negedge clk);
        check("R9", "pulse valid drops", {63'd0, out_vld}, 64'd0);

        // R11: reset while input is valid clears the register
        in_vld = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "out_vld under reset", {63'd0, out_vld}, 64'd0);
        check("R11", "result under reset", result, 64'd0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual=not finished expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule